// File: doc/BRIEF.md
# Multi-Phase Edge Sampler

This block watches one asynchronous entropy line and captures it at many closely spaced instants instead of once per system clock. A set of N phase-shifted clocks is supplied from outside the block. Each phase clock drives its own pair of capture flip-flops. One flop of the pair fires on the rising edge and the other on the falling edge, and all 2N flops look at the same entropy line. Because the 2N edges are staggered inside one clock period, the line is much more likely to be caught while it is moving, which is where sampling uncertainty gives the most entropy.

The 2N captured bits are then taken into the system-clock domain by a resampling pipeline with a configurable depth. They leave the block as one parallel vector on every system clock, together with a valid strobe. The vector feeds a post-processing stage that sits outside this block. The ring oscillator that makes the entropy line and the generator of the phase clocks are also outside.

Top module: `multiphase_edge_sampler`

## Requirements
- R1: The block has 2N capture flip-flops (N = NUM_PHASES, default 3, which gives a 6-bit vector). Each edge of each phase clock, rising and falling, owns exactly one of them.
- R2: In `sample_vec`, bit 2k holds the rising-edge sample of phase clock k and bit 2k+1 holds its falling-edge sample.
- R3: Every capture flip-flop samples the single `entropy_in` line. Its bit equals the level of that line at its own clock edge.
- R4: An edge on phase clock k updates only bits 2k and 2k+1. All other bits of the vector keep their values.
- R5: Captured bits reach `sample_vec` only through the system-clock resampling pipeline. The vector shows the capture state RESYNC_STAGES rising `clk_sys` edges (default 1) after the last phase edge.
- R6: A change of `entropy_in` with no phase-clock edge has no effect on `sample_vec`.
- R7: `rst_n` is an active-low synchronous reset. It clears each capture flop on that flop's own clock edge and clears the resampling pipeline on `clk_sys`, so the vector reads 0.
- R8: `sample_valid` is 0 while reset is held. It rises on the RESYNC_STAGES-th rising `clk_sys` edge after release (the first edge by default) and then stays high, so one vector arrives on every system clock.
- R9: While `sample_valid` is low, `sample_vec` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; resampling pipeline and valid strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_clk | input | NUM_PHASES | Phase-shifted sampling clocks; bit k drives capture pair k |
| entropy_in | input | 1 | Asynchronous entropy line shared by all capture flops |
| sample_vec | output | 2*NUM_PHASES | Resampled vector; bit 2k rising, bit 2k+1 falling sample of phase k |
| sample_valid | output | 1 | High on every system clock once the pipeline holds post-reset data |

## Verification
A capture bit changes at the phase edge itself. The vector reflects it after RESYNC_STAGES rising system-clock edges, which is one edge by default. `sample_valid` rises on the first system edge after reset release. The bench places all phase edges of a scenario just after a falling system edge, well before the next rising edge. It then waits RESYNC_STAGES rising edges and samples on the following falling edge, so every result is read in the cycle it becomes due. Before the rising edge it checks the not-yet-due state, such as a low `sample_valid` right after release. For hold checks it lets many cycles pass with no phase edge and confirms the vector is unchanged.

// File: rtl/msu_pkg.sv
package msu_pkg;
   typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;

   localparam int unsigned MAX_RESYNC_STAGES = 3;

   function automatic int unsigned vec_width(input int unsigned phases);
      return 2 * phases;
   endfunction
endpackage

// File: rtl/msu_edge_flop.sv
module msu_edge_flop #(
   parameter msu_pkg::edge_kind_e EDGE = msu_pkg::EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (EDGE == msu_pkg::EDGE_RISE) begin : g_rise
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d;
         end
      end else begin : g_fall
         always_ff @(negedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/msu_resample.sv
module msu_resample #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/msu_valid_gen.sv
module msu_valid_gen #(
   parameter int unsigned STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic valid
);
   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) valid <= 1'b0;
            else        valid <= 1'b1;
         end
      end else begin : g_chain
         logic [STAGES-1:0] fill;
         always_ff @(posedge clk) begin
            if (!rst_n) fill <= '0;
            else        fill <= {fill[STAGES-2:0], 1'b1};
         end
         assign valid = fill[STAGES-1];
      end
   endgenerate

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> valid); // R8
endmodule

// File: rtl/multiphase_edge_sampler.sv
module multiphase_edge_sampler #(
   parameter int unsigned NUM_PHASES    = 3,
   parameter int unsigned RESYNC_STAGES = 1
) (
   input  logic                      clk_sys,
   input  logic                      rst_n,
   input  logic [NUM_PHASES-1:0]     phase_clk,
   input  logic                      entropy_in,
   output logic [2*NUM_PHASES-1:0]   sample_vec,
   output logic                      sample_valid
);
   localparam int unsigned VW = msu_pkg::vec_width(NUM_PHASES);

   generate
      if (NUM_PHASES < 1) begin : g_bad_phases
         $error("NUM_PHASES must be at least 1");
      end
      if (RESYNC_STAGES < 1 || RESYNC_STAGES > msu_pkg::MAX_RESYNC_STAGES) begin : g_bad_stages
         $error("RESYNC_STAGES out of range");
      end
   endgenerate

   logic [VW-1:0] cap_bus;

   for (genvar k = 0; k < int'(NUM_PHASES); k++) begin : g_pair
      msu_edge_flop #(.EDGE(msu_pkg::EDGE_RISE)) u_rise (
         .clk(phase_clk[k]), .rst_n(rst_n), .d(entropy_in), .q(cap_bus[2*k]));
      msu_edge_flop #(.EDGE(msu_pkg::EDGE_FALL)) u_fall (
         .clk(phase_clk[k]), .rst_n(rst_n), .d(entropy_in), .q(cap_bus[2*k+1]));
   end

   msu_resample #(.WIDTH(VW), .STAGES(RESYNC_STAGES)) u_resample (
      .clk(clk_sys), .rst_n(rst_n), .d(cap_bus), .q(sample_vec));

   msu_valid_gen #(.STAGES(RESYNC_STAGES)) u_valid (
      .clk(clk_sys), .rst_n(rst_n), .valid(sample_valid));

   AST_ZERO_WHILE_INVALID: assert property (@(posedge clk_sys) disable iff (!rst_n)
      !sample_valid |-> (sample_vec == '0)); // R9

   generate
      if (RESYNC_STAGES == 1) begin : g_single_checks
         AST_VALID_AFTER_RELEASE: assert property (@(posedge clk_sys) disable iff (!rst_n)
            $past(rst_n) |-> sample_valid); // R8
         AST_OUT_TRACKS_CAPTURE: assert property (@(posedge clk_sys) disable iff (!rst_n)
            ($past(rst_n) && $stable(cap_bus)) |-> (sample_vec == cap_bus)); // R5
      end
   endgenerate
endmodule

// File: tb/tb_multiphase_edge_sampler.sv
`timescale 1ns/1ps
module tb_multiphase_edge_sampler;
   localparam int N  = 3;
   localparam int ST = 1;
   localparam int W  = 2 * N;

   logic          clk_sys = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  phase_clk = '0;
   logic          entropy_in = 1'b0;
   logic [W-1:0]  sample_vec;
   logic          sample_valid;

   int errors = 0;
   int checks = 0;

   multiphase_edge_sampler #(.NUM_PHASES(N), .RESYNC_STAGES(ST)) dut (
      .clk_sys(clk_sys), .rst_n(rst_n), .phase_clk(phase_clk),
      .entropy_in(entropy_in), .sample_vec(sample_vec), .sample_valid(sample_valid));

   always #4 clk_sys = ~clk_sys;

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Staggered edges: rising edges of phases 0..N-1, then falling edges 0..N-1.
   // entropy_in is set before each edge to the bit that edge should capture.
   task automatic sweep(input logic [W-1:0] pat);
      @(negedge clk_sys);
      for (int k = 0; k < N; k++) begin
         #0.2 entropy_in = pat[2*k];
         #0.3 phase_clk[k] = 1'b1;
      end
      for (int k = 0; k < N; k++) begin
         #0.2 entropy_in = pat[2*k+1];
         #0.3 phase_clk[k] = 1'b0;
      end
   endtask

   task automatic wait_due();
      repeat (ST) @(posedge clk_sys);
      @(negedge clk_sys);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      sweep('1);
      sweep('1);
      wait_due();
      check(sample_vec == '0, "R7 reset clears vector", sample_vec, '0);
      check(sample_valid == 1'b0, "R8 valid low in reset", W'(sample_valid), '0);
      check(sample_vec == '0, "R9 zero while invalid", sample_vec, '0);
   endtask

   task automatic t_valid();
      @(negedge clk_sys);
      rst_n = 1'b1;
      #1;
      check(sample_valid == 1'b0, "R8 valid not yet due", W'(sample_valid), '0);
      wait_due();
      check(sample_valid == 1'b1, "R8 valid after release", W'(sample_valid), W'(1));
      begin
         bit stayed = 1'b1;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk_sys);
            if (!sample_valid) stayed = 1'b0;
         end
         check(stayed, "R8 valid stays high", W'(stayed), W'(1));
      end
   endtask

   task automatic t_pattern(input logic [W-1:0] pat);
      sweep(pat);
      wait_due();
      check(sample_vec == pat, "R1 R2 R3 per-edge capture", sample_vec, pat);
   endtask

   task automatic t_single_phase(input int k);
      logic [W-1:0] exp;
      t_pattern('0);
      @(negedge clk_sys);
      #0.2 entropy_in = 1'b1;
      #0.3 phase_clk[k] = 1'b1;
      #0.5 phase_clk[k] = 1'b0;
      wait_due();
      exp = '0;
      exp[2*k]   = 1'b1;
      exp[2*k+1] = 1'b1;
      check(sample_vec == exp, "R4 only own pair updates", sample_vec, exp);
   endtask

   task automatic t_hold();
      logic [W-1:0] pat = 6'b011010;
      t_pattern(pat);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk_sys);
         entropy_in = ~entropy_in;
      end
      wait_due();
      check(sample_vec == pat, "R6 data change without phase edge ignored", sample_vec, pat);
      check(sample_vec == pat, "R5 vector held between phase edges", sample_vec, pat);
   endtask

   task automatic t_reset_mid();
      t_pattern('1);
      t_reset();
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_valid();
      t_pattern(6'b000000);
      t_pattern(6'b111111);
      t_pattern(6'b101010);
      t_pattern(6'b010101);
      t_pattern(6'b100110);
      t_pattern(6'b011001);
      t_pattern(6'b000001);
      t_pattern(6'b100000);
      for (int k = 0; k < N; k++) t_single_phase(k);
      t_hold();
      t_reset_mid();
      t_valid();
      t_pattern(6'b110100);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule